// File: doc/BRIEF.md
# Chunky-to-Planar Pixel Transposer

This block turns packed pixel data, one byte per pixel, into bitplane words for a planar frame buffer. Pixels arrive in groups of sixteen on a 128-bit input. Each group passes through a three-stage swap network that exchanges nibbles, then bit pairs, then single bits. The network leaves a 16-bit word for every bitplane, and the block sends those words out one per cycle. Each word carries the byte address where it belongs in the frame buffer.

A frame is set up with a pulse on `start`. The same cycle supplies a base address, a plane modulo (the byte distance between planes) and a line modulo (the byte distance between line starts), along with the frame width, the frame height and the plane count. The address moves forward by the plane modulo for each plane. After the last plane of a group it returns to plane 0 of the next word. At the end of a line it jumps to the start of the next line. Both sides use valid/ready handshakes. A new group is accepted only after every plane word of the previous group has gone out.

Top module: `c2p_transposer`

## Requirements
- R1: Pixel k (0..15) of a group is `in_data[127-8k -: 8]`. Bit (15-k) of the output word for plane p equals bit p of pixel k, so pixel 0 lands in the MSB.
- R2: Plane words of a group are emitted in ascending order starting at plane 0. With `cfg_full`=1 there are eight words (planes 0..7). With `cfg_full`=0 there are six (planes 0..5). `out_plane` gives the plane number.
- R3: The word for plane p of group g (16-pixel column) on line y has `out_addr` = base + y*line_mod + 2*g + p*plane_mod, computed modulo 2^ADDR_W.
- R4: `in_ready` is high only while the block waits for a group, never together with `out_valid`. Input presented while plane words are pending is not taken and does not change the words being sent.
- R5: While `out_valid` is high and `out_ready` is low, `out_word`, `out_addr` and `out_plane` hold steady.
- R6: `done` is high for exactly one cycle, the cycle after the last word of the last line is accepted. `busy` is low in that cycle.
- R7: A start is rejected when the width is zero or not a multiple of 32, or when the height is zero or odd. In that case `cfg_err` goes high, the block stays idle and no input is requested. The next accepted start clears `cfg_err`.
- R8: A `start` pulse while `busy` is high is ignored. The running frame is not restarted or extended.
- R9: Configuration inputs are sampled only at an accepted start. Changing them during a frame does not affect plane count or addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame using the configuration inputs |
| cfg_full | input | 1 | 1: eight planes, 0: six planes |
| cfg_base | input | ADDR_W | Byte address of plane 0, first word, first line |
| cfg_plane_mod | input | ADDR_W | Byte distance between consecutive planes |
| cfg_line_mod | input | ADDR_W | Byte distance between consecutive line starts |
| cfg_width | input | DIM_W | Frame width in pixels |
| cfg_height | input | DIM_W | Frame height in lines |
| in_valid | input | 1 | Group of sixteen pixels offered |
| in_ready | output | 1 | Block accepts a group |
| in_data | input | 128 | Sixteen packed 8-bit pixels, pixel 0 in the top byte |
| out_valid | output | 1 | Plane word offered |
| out_ready | input | 1 | Receiver takes the plane word |
| out_word | output | 16 | Bitplane word |
| out_plane | output | 3 | Plane number of `out_word` |
| out_addr | output | ADDR_W | Byte address of `out_word` |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at end of frame |
| cfg_err | output | 1 | Last start was rejected for bad geometry |

## Verification
The bench uses the default ADDR_W=32 and DIM_W=12. With these values, frames two to four groups wide and two or four lines tall finish in a few hundred cycles. This covers the group-to-group return step, the line step and both plane counts. One frame places its base near the top of the 32-bit space and uses a line modulo that counts downward, so the precomputed return and line steps must wrap the same way as the direct address formula.

// File: rtl/c2p_pkg.sv
package c2p_pkg;
  localparam int GRP_PIX    = 16;
  localparam int PIX_W      = 8;
  localparam int IN_W       = GRP_PIX * PIX_W;
  localparam int PLANE_W    = GRP_PIX;
  localparam int MAX_PLANES = PIX_W;
  localparam int PIDX_W     = $clog2(MAX_PLANES);
  localparam int HALF_ROWS  = PIX_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_EMIT = 2'd2
  } c2p_state_e;

  // Bits kept by the lower row of a swap pair at distance s.
  function automatic logic [PIX_W-1:0] keep_low_mask(input int s);
    logic [PIX_W-1:0] m;
    for (int b = 0; b < PIX_W; b++) begin
      m[b] = ((b / s) % 2) == 0;
    end
    return m;
  endfunction
endpackage

// File: rtl/c2p_swap_stage.sv
// One stage of the bit-matrix transpose: rows SHIFT apart exchange the
// off-diagonal SHIFT x SHIFT blocks, inside each 8x8 half independently.
module c2p_swap_stage
  import c2p_pkg::*;
#(
  parameter int SHIFT = 4
) (
  input  logic [GRP_PIX-1:0][PIX_W-1:0] rows_i,
  output logic [GRP_PIX-1:0][PIX_W-1:0] rows_o
);
  localparam logic [PIX_W-1:0] LO_MASK = keep_low_mask(SHIFT);
  localparam logic [PIX_W-1:0] HI_MASK = ~LO_MASK;
  localparam int NUM_HALVES = GRP_PIX / HALF_ROWS;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    for (genvar r = 0; r < HALF_ROWS; r++) begin : g_row
      localparam int IDX = h * HALF_ROWS + r;
      if ((r & SHIFT) == 0) begin : g_upper
        assign rows_o[IDX] = (rows_i[IDX] & HI_MASK)
                           | ((rows_i[IDX + SHIFT] & HI_MASK) >> SHIFT);
      end else begin : g_lower
        assign rows_o[IDX] = ((rows_i[IDX - SHIFT] & LO_MASK) << SHIFT)
                           | (rows_i[IDX] & LO_MASK);
      end
    end
  end
endmodule

// File: rtl/c2p_transpose.sv
// Combinational 16-pixel transpose: nibble swap, pair swap, single-bit swap.
module c2p_transpose
  import c2p_pkg::*;
(
  input  logic [IN_W-1:0]                       pix_i,
  output logic [MAX_PLANES-1:0][PLANE_W-1:0]    planes_o
);
  localparam int NUM_STAGES = $clog2(PIX_W);

  logic [NUM_STAGES:0][GRP_PIX-1:0][PIX_W-1:0] stage;

  for (genvar k = 0; k < GRP_PIX; k++) begin : g_unpack
    assign stage[0][k] = pix_i[IN_W-1-k*PIX_W -: PIX_W];
  end

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    c2p_swap_stage #(
      .SHIFT (PIX_W >> (s + 1))
    ) swap_i (
      .rows_i (stage[s]),
      .rows_o (stage[s+1])
    );
  end

  // After the transpose, row c of each half holds plane (PIX_W-1-c).
  for (genvar p = 0; p < MAX_PLANES; p++) begin : g_pack
    assign planes_o[p] = {stage[NUM_STAGES][HALF_ROWS-1-p],
                          stage[NUM_STAGES][2*HALF_ROWS-1-p]};
  end
endmodule

// File: rtl/c2p_addr_gen.sv
// Single address accumulator with three precomputed steps.
module c2p_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] plane_mod,
  input  logic [ADDR_W-1:0] line_mod,
  input  logic [DIM_W-1:0]  width,
  input  logic              full,
  input  logic              step_plane,
  input  logic              step_group,
  input  logic              step_line,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(2);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] pmod_q, pmod_d;
  logic [ADDR_W-1:0] ret_q,  ret_d;
  logic [ADDR_W-1:0] lstep_q, lstep_d;
  logic [ADDR_W-1:0] ret_calc;
  logic [ADDR_W-1:0] line_bytes;
  logic              addr_en;

  always_comb begin
    // distance from last plane back to plane 0, minus one word forward
    if (full) begin
      ret_calc = (plane_mod << 3) - plane_mod - WORD_BYTES;
    end else begin
      ret_calc = (plane_mod << 2) + plane_mod - WORD_BYTES;
    end
    line_bytes = {{(ADDR_W-DIM_W){1'b0}}, width} >> 3;
  end

  always_comb begin
    pmod_d  = pmod_q;
    ret_d   = ret_q;
    lstep_d = lstep_q;
    addr_d  = addr_q;
    if (load) begin
      pmod_d  = plane_mod;
      ret_d   = ret_calc;
      lstep_d = line_mod - line_bytes - ret_calc;
      addr_d  = base;
    end else if (step_plane) begin
      addr_d = addr_q + pmod_q;
    end else if (step_group) begin
      addr_d = addr_q - ret_q;
    end else if (step_line) begin
      addr_d = addr_q + lstep_q;
    end
  end

  assign addr_en = load | step_plane | step_group | step_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      pmod_q  <= '0;
      ret_q   <= '0;
      lstep_q <= '0;
    end else if (addr_en) begin
      addr_q  <= addr_d;
      pmod_q  <= pmod_d;
      ret_q   <= ret_d;
      lstep_q <= lstep_d;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/c2p_seq.sv
// Frame sequencer: geometry check, load/emit alternation, counters.
module c2p_seq
  import c2p_pkg::*;
#(
  parameter int DIM_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_full,
  input  logic [DIM_W-1:0]  cfg_width,
  input  logic [DIM_W-1:0]  cfg_height,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              load_cfg,
  output logic              capture,
  output logic              step_plane,
  output logic              step_group,
  output logic              step_line,
  output logic [PIDX_W-1:0] plane_idx,
  output logic [PIDX_W-1:0] last_plane,
  output logic              busy,
  output logic              done,
  output logic              cfg_err
);
  localparam logic [DIM_W-1:0]  DIM_ONE   = DIM_W'(1);
  localparam logic [PIDX_W-1:0] PIDX_ONE  = PIDX_W'(1);
  localparam logic [PIDX_W-1:0] LAST_FULL = PIDX_W'(MAX_PLANES - 1);
  localparam logic [PIDX_W-1:0] LAST_RED  = PIDX_W'(MAX_PLANES - 3);

  c2p_state_e        state_q, state_d;
  logic [PIDX_W-1:0] plane_q, plane_d;
  logic [DIM_W-1:0]  grp_q, grp_d;
  logic [DIM_W-1:0]  line_q, line_d;
  logic [DIM_W-1:0]  grp_last_q, grp_last_d;
  logic [DIM_W-1:0]  line_last_q, line_last_d;
  logic              full_q, full_d;
  logic              err_q, err_d;
  logic              done_q, done_d;
  logic              geom_ok;
  logic              emit_fire;
  logic              cnt_en;

  assign geom_ok = (cfg_width[4:0] == 5'd0) && (cfg_width != '0)
                && !cfg_height[0] && (cfg_height != '0);

  assign last_plane = full_q ? LAST_FULL : LAST_RED;
  assign in_ready   = (state_q == ST_LOAD);
  assign out_valid  = (state_q == ST_EMIT);
  assign emit_fire  = out_valid & out_ready;

  always_comb begin
    state_d     = state_q;
    plane_d     = plane_q;
    grp_d       = grp_q;
    line_d      = line_q;
    grp_last_d  = grp_last_q;
    line_last_d = line_last_q;
    full_d      = full_q;
    err_d       = err_q;
    done_d      = 1'b0;
    load_cfg    = 1'b0;
    capture     = 1'b0;
    step_plane  = 1'b0;
    step_group  = 1'b0;
    step_line   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (geom_ok) begin
            state_d     = ST_LOAD;
            load_cfg    = 1'b1;
            err_d       = 1'b0;
            full_d      = cfg_full;
            grp_d       = '0;
            line_d      = '0;
            grp_last_d  = (cfg_width >> 4) - DIM_ONE;
            line_last_d = cfg_height - DIM_ONE;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_LOAD: begin
        if (in_valid) begin
          capture = 1'b1;
          plane_d = '0;
          state_d = ST_EMIT;
        end
      end
      ST_EMIT: begin
        if (out_ready) begin
          if (plane_q != last_plane) begin
            plane_d    = plane_q + PIDX_ONE;
            step_plane = 1'b1;
          end else if (grp_q != grp_last_q) begin
            grp_d      = grp_q + DIM_ONE;
            step_group = 1'b1;
            state_d    = ST_LOAD;
          end else if (line_q != line_last_q) begin
            line_d    = line_q + DIM_ONE;
            grp_d     = '0;
            step_line = 1'b1;
            state_d   = ST_LOAD;
          end else begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cnt_en = load_cfg | capture | emit_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plane_q     <= '0;
      grp_q       <= '0;
      line_q      <= '0;
      grp_last_q  <= '0;
      line_last_q <= '0;
      full_q      <= 1'b0;
    end else if (cnt_en) begin
      plane_q     <= plane_d;
      grp_q       <= grp_d;
      line_q      <= line_d;
      grp_last_q  <= grp_last_d;
      line_last_q <= line_last_d;
      full_q      <= full_d;
    end
  end

  assign plane_idx = plane_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign cfg_err   = err_q;
endmodule

// File: rtl/c2p_transposer.sv
module c2p_transposer
  import c2p_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_full,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_plane_mod,
  input  logic [ADDR_W-1:0] cfg_line_mod,
  input  logic [DIM_W-1:0]  cfg_width,
  input  logic [DIM_W-1:0]  cfg_height,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IN_W-1:0]   in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PLANE_W-1:0] out_word,
  output logic [PIDX_W-1:0] out_plane,
  output logic [ADDR_W-1:0] out_addr,
  output logic              busy,
  output logic              done,
  output logic              cfg_err
);
  logic [MAX_PLANES-1:0][PLANE_W-1:0] tp_planes;
  logic [MAX_PLANES-1:0][PLANE_W-1:0] plane_q, plane_d;
  logic              load_cfg;
  logic              capture;
  logic              step_plane;
  logic              step_group;
  logic              step_line;
  logic [PIDX_W-1:0] plane_idx;
  logic [PIDX_W-1:0] last_plane;

  c2p_seq #(
    .DIM_W (DIM_W)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cfg_full   (cfg_full),
    .cfg_width  (cfg_width),
    .cfg_height (cfg_height),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .load_cfg   (load_cfg),
    .capture    (capture),
    .step_plane (step_plane),
    .step_group (step_group),
    .step_line  (step_line),
    .plane_idx  (plane_idx),
    .last_plane (last_plane),
    .busy       (busy),
    .done       (done),
    .cfg_err    (cfg_err)
  );

  c2p_transpose tp_i (
    .pix_i    (in_data),
    .planes_o (tp_planes)
  );

  c2p_addr_gen #(
    .ADDR_W (ADDR_W),
    .DIM_W  (DIM_W)
  ) addr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_cfg),
    .base       (cfg_base),
    .plane_mod  (cfg_plane_mod),
    .line_mod   (cfg_line_mod),
    .width      (cfg_width),
    .full       (cfg_full),
    .step_plane (step_plane),
    .step_group (step_group),
    .step_line  (step_line),
    .addr       (out_addr)
  );

  always_comb begin
    plane_d = plane_q;
    if (capture) begin
      plane_d = tp_planes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plane_q <= '0;
    end else if (capture) begin
      plane_q <= plane_d;
    end
  end

  assign out_word  = plane_q[plane_idx];
  assign out_plane = plane_idx;
endmodule

// File: rtl/c2p_transposer_chk.sv
module c2p_transposer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [15:0]       out_word,
  input logic [2:0]        out_plane,
  input logic [ADDR_W-1:0] out_addr,
  input logic [2:0]        last_plane,
  input logic              busy,
  input logic              done,
  input logic              cfg_err
);
  assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word)
      && $stable(out_addr) && $stable(out_plane));

  assert_first_plane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && (out_plane == 3'd0));

  assert_next_plane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && (out_plane != last_plane)
      |=> out_valid && (out_plane == 3'($past(out_plane) + 3'd1)));

  assert_plane_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_plane <= last_plane));

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy && !in_ready && !out_valid);
endmodule

bind c2p_transposer c2p_transposer_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/c2p_transposer_tb.sv
module c2p_transposer_tb_top;
  localparam int ADDR_W = 32;
  localparam int DIM_W  = 12;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic              cfg_full;
  logic [ADDR_W-1:0] cfg_base;
  logic [ADDR_W-1:0] cfg_plane_mod;
  logic [ADDR_W-1:0] cfg_line_mod;
  logic [DIM_W-1:0]  cfg_width;
  logic [DIM_W-1:0]  cfg_height;
  logic              in_valid;
  logic              in_ready;
  logic [127:0]      in_data;
  logic              out_valid;
  logic              out_ready;
  logic [15:0]       out_word;
  logic [2:0]        out_plane;
  logic [ADDR_W-1:0] out_addr;
  logic              busy;
  logic              done;
  logic              cfg_err;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  c2p_transposer #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_full(cfg_full),
    .cfg_base(cfg_base), .cfg_plane_mod(cfg_plane_mod),
    .cfg_line_mod(cfg_line_mod), .cfg_width(cfg_width),
    .cfg_height(cfg_height), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_plane(out_plane), .out_addr(out_addr),
    .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL [%s] %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_data(input int pat, input int n);
    logic [127:0] d;
    logic [31:0]  x;
    for (int k = 0; k < 16; k++) begin
      case (pat)
        1: d[127-8*k -: 8] = 8'h01 << (k % 8);
        2: d[127-8*k -: 8] = (k % 2 == 0) ? 8'hFF : 8'h00;
        default: begin
          x = 32'(n * 16 + k + 1) * 32'h9E37_79B9;
          d[127-8*k -: 8] = x[31:24] ^ x[7:0];
        end
      endcase
    end
    return d;
  endfunction

  // bit (15-k) of plane p = bit p of pixel k
  function automatic logic [15:0] ref_plane(input logic [127:0] d, input int p);
    logic [15:0] w;
    for (int k = 0; k < 16; k++) begin
      w[15-k] = d[120-8*k+p];
    end
    return w;
  endfunction

  task automatic t_reset;
    chk(in_ready === 1'b0, "R4", "in_ready after reset", 64'(in_ready), 0);
    chk(out_valid === 1'b0, "R5", "out_valid after reset", 64'(out_valid), 0);
    chk(busy === 1'b0, "R6", "busy after reset", 64'(busy), 0);
    chk(done === 1'b0, "R6", "done after reset", 64'(done), 0);
    chk(cfg_err === 1'b0, "R7", "cfg_err after reset", 64'(cfg_err), 0);
  endtask

  task automatic run_frame(input bit full, input int w, input int h,
                           input logic [31:0] base, input logic [31:0] pm,
                           input logic [31:0] lm, input int pat,
                           input bit stall, input bit poke);
    int n_pl = full ? 8 : 6;
    int grps = w / 16;
    logic [127:0] d;
    logic [15:0]  held;
    logic [31:0]  ea;
    @(negedge clk);
    cfg_full = full; cfg_base = base; cfg_plane_mod = pm; cfg_line_mod = lm;
    cfg_width = DIM_W'(w); cfg_height = DIM_W'(h);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err === 1'b0, "R7", "cfg_err cleared by good start", 64'(cfg_err), 0);
    chk(busy === 1'b1, "R6", "busy after start", 64'(busy), 1);
    for (int y = 0; y < h; y++) begin
      for (int g = 0; g < grps; g++) begin
        d = mk_data(pat, y * grps + g);
        in_data = d; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        if (stall) in_data = ~d;  // R4: offered while pending, must be ignored
        else in_valid = 1'b0;
        if (poke && y == 0 && g == 0) begin
          start = 1'b1; cfg_base = ~base; cfg_full = ~full;
          cfg_plane_mod = pm + 32'd4; cfg_line_mod = lm + 32'd8;
          @(negedge clk);
          start = 1'b0;
        end
        for (int p = 0; p < n_pl; p++) begin
          if (stall && (p % 3 == 1)) begin
            held = out_word;
            out_ready = 1'b0;
            repeat (2) @(negedge clk);
            chk(out_valid === 1'b1 && out_word === held, "R5",
                "word held under back-pressure", 64'(out_word), 64'(held));
          end
          ea = base + 32'(y) * lm + 32'(2 * g) + 32'(p) * pm;
          chk(out_valid === 1'b1, "R2", "out_valid for plane", 64'(out_valid), 1);
          chk(in_ready === 1'b0, "R4", "in_ready while words pending", 64'(in_ready), 0);
          chk(out_plane === 3'(p), "R2", "plane order", 64'(out_plane), 64'(p));
          chk(out_word === ref_plane(d, p), "R1", "plane word",
              64'(out_word), 64'(ref_plane(d, p)));
          chk(out_addr === ea, poke ? "R9" : "R3", "plane address",
              64'(out_addr), 64'(ea));
          out_ready = 1'b1;
          @(negedge clk);
          out_ready = 1'b0;
        end
      end
    end
    in_valid = 1'b0;
    chk(done === 1'b1, "R6", "done after last word", 64'(done), 1);
    chk(busy === 1'b0, "R6", "busy with done", 64'(busy), 0);
    @(negedge clk);
    chk(done === 1'b0, "R6", "done is one cycle", 64'(done), 0);
    if (poke) begin
      chk(busy === 1'b0 && out_valid === 1'b0, "R8", "no restart from ignored start",
          64'(busy), 0);
    end
  endtask

  task automatic t_full_hash;
    run_frame(1'b1, 32, 2, 32'h0001_0000, 32'h0000_2000, 32'h0000_0050, 0, 1'b0, 1'b0);
  endtask

  task automatic t_reduced_stall;
    run_frame(1'b0, 64, 2, 32'h0002_0100, 32'h0000_1F40, 32'h0000_0028, 0, 1'b1, 1'b0);
  endtask

  task automatic t_patterns;
    run_frame(1'b1, 32, 2, 32'h0000_0000, 32'h0000_0100, 32'h0000_0010, 1, 1'b0, 1'b0);
    run_frame(1'b0, 32, 2, 32'h0000_4000, 32'h0000_0200, 32'h0000_0020, 2, 1'b1, 1'b0);
  endtask

  task automatic t_wrap;
    run_frame(1'b1, 32, 4, 32'hFFFF_FF00, 32'h0000_0040, 32'hFFFF_FFE0, 0, 1'b0, 1'b0);
  endtask

  task automatic t_bad_geometry;
    int bw[3] = '{48, 32, 0};
    int bh[3] = '{2, 3, 2};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      cfg_width = DIM_W'(bw[i]); cfg_height = DIM_W'(bh[i]); cfg_full = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(cfg_err === 1'b1, "R7", "cfg_err on bad geometry", 64'(cfg_err), 1);
      chk(busy === 1'b0 && in_ready === 1'b0, "R7", "idle on bad geometry",
          64'({busy, in_ready}), 0);
      @(negedge clk);
      chk(out_valid === 1'b0, "R7", "no output on bad geometry", 64'(out_valid), 0);
    end
  endtask

  task automatic t_poke;
    run_frame(1'b0, 32, 2, 32'h0003_0000, 32'h0000_0800, 32'h0000_0030, 0, 1'b0, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; cfg_full = 1'b0; cfg_base = '0;
    cfg_plane_mod = '0; cfg_line_mod = '0; cfg_width = '0; cfg_height = '0;
    in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_hash();
    t_reduced_stall();
    t_patterns();
    t_wrap();
    t_bad_geometry();
    t_poke();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL [R6] watchdog: actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule